// File: doc/BRIEF.md
# Dual-Slot SD Host Glue Register Block

This block is the shared register front end placed ahead of one or two SD host controller slots. Software reaches it through a 32-bit register port inside a 4 KiB window. The low 256 bytes hold the glue registers: a global information word with slot-presence flags and a self-clearing controller-reset request, plus debounce, bus, write-protect polarity and card-detect words. The same range also holds an interrupt-status word and, for each slot, a writable capability word and a writable maximum-current word. The capability and maximum-current words drive the slots' configuration inputs directly.

Each slot's own register window begins at offset (i+1)*0x100. The block does not store accesses in that window. It only raises a select strobe to that slot in the same cycle as the access. The interrupt lines from the slots are captured into the status word, and their OR forms one combined interrupt output. Read data is registered and appears one cycle after the read strobe.

Top module: `sdglue_regs`

## Requirements
- R1: After reset the information word reads 0x00010000 with one slot, or 0x00030000 with two slots (bit 16 marks slot 0, bit 17 marks slot 1). The debounce word reads 0x00000005. Every other word reads zero, and all slot_cap and slot_maxcur outputs are zero.
- R2: Data for a read issued in cycle t appears on rsp_rdata in cycle t+1. rsp_rdata then holds its value until the next read.
- R3: A write to the information word (offset 0x00) stores bits 31..1. Bit 0 always reads back as 0.
- R4: A write to offset 0x00 with bit 0 set makes ctl_reset_pulse high for exactly the next cycle. A write with bit 0 clear leaves ctl_reset_pulse low.
- R5: The debounce (0x04), bus (0x08), write-protect polarity (0xEC) and card-detect (0xF0) words read back the full 32 bits last written.
- R6: Slot k has a capability word at 0x10+0x10*k and a maximum-current word at 0x18+0x10*k. Both read back the full 32 bits written. Each drives bits [32k+31:32k] of slot_cap or slot_maxcur from the cycle after the write.
- R7: Bit n of the interrupt-status word (0xFC) equals slot_irq_in[n] as sampled at the previous clock edge. Bits above the slot count read 0, and writes to 0xFC have no effect.
- R8: irq_out is high exactly when at least one interrupt-status bit is set. One slot dropping its line does not hide the other slot's pending interrupt.
- R9: A read or write with an address in 0x100*(i+1) .. 0x100*(i+1)+0xFF raises slot_sel[i] combinationally in that cycle. At most one select bit is high at a time. Such accesses change no glue register, and a read there returns 0.
- R10: Reads of unmapped offsets (for example 0x0C, 0x80, or 0x300 with two slots) return 0. Writes to them change no register.
- R11: When a read and a write to the same word fall in one cycle, the read returns the contents from before the write. A read of 0xFC in the cycle in which a slot line changes returns the status from before that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write strobe, one cycle per access |
| req_rd | input | 1 | Read strobe, one cycle per access |
| req_addr | input | ADDR_W | Byte offset within the 4 KiB window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| slot_irq_in | input | NUM_SLOTS | Interrupt line from each slot |
| irq_out | output | 1 | Combined interrupt |
| ctl_reset_pulse | output | 1 | One-cycle controller reset request |
| slot_sel | output | NUM_SLOTS | Per-slot window select strobe |
| slot_cap | output | 32*NUM_SLOTS | Capability word for each slot |
| slot_maxcur | output | 32*NUM_SLOTS | Maximum-current word for each slot |

## Verification
Two of the block's functions can fall in the same cycle. One case is a slot interrupt line changing while software reads the status word; the other is a write and a read of the same word in one cycle. The bench provokes the first by moving slot_irq_in in the same cycle as a read of 0xFC. It expects the old status, and the new status on the following read. For the second it drives req_wr and req_rd together on the debounce word, expects the pre-write value, and then reads again to see the new one.

// File: rtl/sdglue_regs.sv
module sdglue_regs #(
  parameter int NUM_SLOTS = 2,
  parameter int ADDR_W    = 12,
  parameter logic [31:0] DBNC_RST = 32'h0000_0005
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_wr,
  input  logic                    req_rd,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [31:0]             req_wdata,
  output logic [31:0]             rsp_rdata,
  input  logic [NUM_SLOTS-1:0]    slot_irq_in,
  output logic                    irq_out,
  output logic                    ctl_reset_pulse,
  output logic [NUM_SLOTS-1:0]    slot_sel,
  output logic [32*NUM_SLOTS-1:0] slot_cap,
  output logic [32*NUM_SLOTS-1:0] slot_maxcur
);

  localparam int PAGE_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] INFO_OFS = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] DBNC_OFS = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] BUS_OFS  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] WPP_OFS  = ADDR_W'(12'h0EC);
  localparam logic [ADDR_W-1:0] CDET_OFS = ADDR_W'(12'h0F0);
  localparam logic [ADDR_W-1:0] IST_OFS  = ADDR_W'(12'h0FC);
  localparam int CAP_OFS   = 'h10;
  localparam int MAXC_OFS  = 'h18;
  localparam int SLOT_STEP = 'h10;
  localparam logic [31:0] INFO_RST = (NUM_SLOTS == 2) ? 32'h0003_0000 : 32'h0001_0000;

  logic [31:0] info_q, dbnc_q, bus_q, wpp_q, cdet_q;
  logic [31:0] cap_q  [NUM_SLOTS];
  logic [31:0] maxc_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] irq_stat_q;
  logic [31:0] rd_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      info_q <= INFO_RST;
      dbnc_q <= DBNC_RST;
      bus_q  <= '0;
      wpp_q  <= '0;
      cdet_q <= '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
        cap_q[k]  <= '0;
        maxc_q[k] <= '0;
      end
    end else if (req_wr) begin
      if (req_addr == INFO_OFS) info_q <= {req_wdata[31:1], 1'b0};
      if (req_addr == DBNC_OFS) dbnc_q <= req_wdata;
      if (req_addr == BUS_OFS)  bus_q  <= req_wdata;
      if (req_addr == WPP_OFS)  wpp_q  <= req_wdata;
      if (req_addr == CDET_OFS) cdet_q <= req_wdata;
      for (int k = 0; k < NUM_SLOTS; k++) begin
        if (req_addr == ADDR_W'(CAP_OFS + SLOT_STEP * k))  cap_q[k]  <= req_wdata;
        if (req_addr == ADDR_W'(MAXC_OFS + SLOT_STEP * k)) maxc_q[k] <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_stat_q      <= '0;
      ctl_reset_pulse <= 1'b0;
    end else begin
      irq_stat_q      <= slot_irq_in;
      ctl_reset_pulse <= req_wr && (req_addr == INFO_OFS) && req_wdata[0];
    end
  end

  assign irq_out = |irq_stat_q;

  always_comb begin
    rd_val = '0;
    if (req_addr == INFO_OFS) rd_val = info_q;
    if (req_addr == DBNC_OFS) rd_val = dbnc_q;
    if (req_addr == BUS_OFS)  rd_val = bus_q;
    if (req_addr == WPP_OFS)  rd_val = wpp_q;
    if (req_addr == CDET_OFS) rd_val = cdet_q;
    if (req_addr == IST_OFS)  rd_val = 32'(irq_stat_q);
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (req_addr == ADDR_W'(CAP_OFS + SLOT_STEP * k))  rd_val = cap_q[k];
      if (req_addr == ADDR_W'(MAXC_OFS + SLOT_STEP * k)) rd_val = maxc_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (req_rd) rsp_rdata <= rd_val;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_sel[i] = (req_wr || req_rd) &&
                         (req_addr[ADDR_W-1:8] == PAGE_W'(i + 1));
    assign slot_cap[32*i +: 32]    = cap_q[i];
    assign slot_maxcur[32*i +: 32] = maxc_q[i];
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R4
  rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset_pulse |-> past_ok && $past(req_wr && req_addr == INFO_OFS && req_wdata[0]));

  // R3
  info_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(req_rd && req_addr == INFO_OFS) |-> rsp_rdata[0] == 1'b0);

  // R9
  slot_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));

  // R8
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> irq_out == $past(|slot_irq_in));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(req_rd) |-> $stable(rsp_rdata));

endmodule

// File: tb/tb_sdglue_regs.sv
module tb_sdglue_regs;
  localparam int NS = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_wr = 1'b0, req_rd = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [NS-1:0] slot_irq_in = '0;
  logic irq_out, ctl_reset_pulse;
  logic [NS-1:0] slot_sel;
  logic [32*NS-1:0] slot_cap, slot_maxcur;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];
  logic pend = 1'b0;

  always #10 clk = ~clk;

  sdglue_regs #(.NUM_SLOTS(NS), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .slot_irq_in(slot_irq_in), .irq_out(irq_out),
    .ctl_reset_pulse(ctl_reset_pulse), .slot_sel(slot_sel),
    .slot_cap(slot_cap), .slot_maxcur(slot_maxcur));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend = req_rd;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 read data with no expected entry actual=%h expected=none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 64'(rsp_rdata), 64'(e));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    req_rd = 1'b1; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_rd = 1'b0;
  endtask

  task automatic rdwr(input logic [11:0] a, input logic [31:0] d, input logic [31:0] e, input string t);
    req_rd = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cap outputs", slot_cap, 64'h0);
    check("R1 maxcur outputs", slot_maxcur, 64'h0);
    check("R1 irq_out", 64'(irq_out), 64'h0);
    rd(12'h000, 32'h0003_0000, "R1 info reset");
    rd(12'h004, 32'h0000_0005, "R1 debounce reset");
    rd(12'h0F0, 32'h0, "R1 card detect reset");
    rd(12'h020, 32'h0, "R1 slot1 cap reset");

    // R2 hold after read
    @(negedge clk);
    check("R2 rdata holds", 64'(rsp_rdata), 64'h0);

    // R3 / R4 info write with reset bit
    wr(12'h000, 32'hA5A5_0003);
    check("R4 reset pulse high", 64'(ctl_reset_pulse), 64'h1);
    @(negedge clk);
    check("R4 reset pulse one cycle", 64'(ctl_reset_pulse), 64'h0);
    rd(12'h000, 32'hA5A5_0002, "R3 info bit0 clear");
    wr(12'h000, 32'h0003_0000);
    check("R4 no pulse when bit0 clear", 64'(ctl_reset_pulse), 64'h0);

    // R5 plain words
    wr(12'h004, 32'h1234_5678);
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h0EC, 32'h8000_0001);
    wr(12'h0F0, 32'h0F0F_F0F0);
    rd(12'h004, 32'h1234_5678, "R5 debounce");
    rd(12'h008, 32'hFFFF_FFFF, "R5 bus");
    rd(12'h0EC, 32'h8000_0001, "R5 wp polarity");
    rd(12'h0F0, 32'h0F0F_F0F0, "R5 card detect");

    // R6 slot words
    wr(12'h010, 32'hC0DE_0000);
    check("R6 slot0 cap output", slot_cap, 64'h0000_0000_C0DE_0000);
    wr(12'h028, 32'h0000_BEEF);
    check("R6 slot1 maxcur output", slot_maxcur, 64'h0000_BEEF_0000_0000);
    wr(12'h020, 32'hAAAA_5555);
    wr(12'h018, 32'h1111_2222);
    rd(12'h010, 32'hC0DE_0000, "R6 slot0 cap read");
    rd(12'h018, 32'h1111_2222, "R6 slot0 maxcur read");
    rd(12'h020, 32'hAAAA_5555, "R6 slot1 cap read");
    rd(12'h028, 32'h0000_BEEF, "R6 slot1 maxcur read");
    check("R6 cap outputs", slot_cap, 64'hAAAA_5555_C0DE_0000);

    // R9 slot windows
    req_wr = 1'b1; req_addr = 12'h104; req_wdata = 32'hDEAD_DEAD;
    #1 check("R9 slot0 select", 64'(slot_sel), 64'h1);
    @(negedge clk);
    req_wr = 1'b0;
    req_rd = 1'b1; req_addr = 12'h2FC;
    exp_q.push_back(32'h0); tag_q.push_back("R9 slot window read zero");
    #1 check("R9 slot1 select", 64'(slot_sel), 64'h2);
    @(negedge clk);
    req_rd = 1'b0;
    #1 check("R9 idle no select", 64'(slot_sel), 64'h0);
    wr(12'h204, 32'h0);
    rd(12'h004, 32'h1234_5678, "R9 glue unchanged by window write");

    // R10 unmapped
    wr(12'h00C, 32'h5555_5555);
    wr(12'h080, 32'h6666_6666);
    wr(12'h300, 32'h7777_7777);
    rd(12'h00C, 32'h0, "R10 unmapped 0x0C");
    rd(12'h080, 32'h0, "R10 unmapped 0x80");
    rd(12'h300, 32'h0, "R10 unmapped 0x300");
    check("R10 caps unchanged", slot_cap, 64'hAAAA_5555_C0DE_0000);

    // R7 / R8 / R11 interrupts
    slot_irq_in = 2'b01;
    rd(12'h0FC, 32'h0, "R11 status read same cycle as irq change");
    check("R8 irq_out slot0", 64'(irq_out), 64'h1);
    rd(12'h0FC, 32'h1, "R7 status slot0");
    wr(12'h0FC, 32'h0);
    rd(12'h0FC, 32'h1, "R7 status write ignored");
    slot_irq_in = 2'b11;
    @(negedge clk);
    rd(12'h0FC, 32'h3, "R7 status both");
    slot_irq_in = 2'b10;
    @(negedge clk);
    check("R8 irq_out stays with slot1", 64'(irq_out), 64'h1);
    rd(12'h0FC, 32'h2, "R7 status slot1 only");
    slot_irq_in = 2'b00;
    @(negedge clk);
    check("R8 irq_out low", 64'(irq_out), 64'h0);

    // R11 read and write same cycle
    rdwr(12'h004, 32'h0BAD_F00D, 32'h1234_5678, "R11 read sees pre-write");
    rd(12'h004, 32'h0BAD_F00D, "R11 read after write");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing read data actual=%0d expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule